// File: doc/BRIEF.md
# Ripple-Synchronized Window Override

This block is the fast-transient helper loop of a voltage-mode buck controller. Two digital comparators tell it when the converter output is more than 3% below or more than 3% above the 1.25 V reference. The main PWM loop supplies two single-cycle pulses: one at the start of each on-time and one at its end. A third comparator reports that the output has passed through its regulation point. When a window condition is confirmed, the block issues an override that replaces the main PWM bit. A downstream mux uses the override whenever the valid flag is high.

The start of an on-time is taken as the inductor-current valley, and its end as the peak. A "too low" condition is accepted only at the end of an on-time, so it counts only when even the ripple peak is still below the window. A "too high" condition is accepted only at the start of an on-time, so it counts only when even the trough is above the window. An accepted condition forces the switch on (too low) or off (too high). The override holds until the output crosses its regulation point. A level from the soft-start sequencer, which goes high once soft-start reaches its 2.0 V point, enables the whole function.

The comparator and crossing levels are asynchronous. Each passes through a synchronizer of `SYNC_STAGES` flops before use. The enable and the two pulses are already synchronous to `clk`.

Top module: `ripple_window_override`

## Requirements
- R1: While reset is held and after its release, `ovr_valid` and `ovr_pwm` are both 0 until a window condition is accepted.
- R2: When `on_reset` is high in a cycle where the synchronized low level is 1, the synchronized high level is 0, the synchronized crossing level is 0, `win_en` is 1 and no override is active, the next cycle shows `ovr_valid`=1 and `ovr_pwm`=1 (force on).
- R3: When `on_set` is high in a cycle where the synchronized high level is 1, the synchronized low level is 0, the synchronized crossing level is 0, `win_en` is 1 and no override is active, the next cycle shows `ovr_valid`=1 and `ovr_pwm`=0 (force off).
- R4: A low level seen only at `on_set`, or a high level seen only at `on_reset`, sets nothing. An output whose ripple reaches back inside the window at the relevant edge never latches.
- R5: An active override keeps its value through any further pulses and comparator levels. It ends in the cycle after the synchronized crossing level is 1, which brings back `ovr_valid`=0 and `ovr_pwm`=0.
- R6: While `win_en` is 0, no override is set. An active override is dropped in the cycle after `win_en` falls.
- R7: When both synchronized comparator levels are 1 at the same time, no override is set at either pulse, and the main PWM bit keeps control.
- R8: A synchronized crossing level of 1 in the cycle of a pulse prevents that pulse from setting an override.
- R9: Comparator and crossing levels take effect `SYNC_STAGES` clock edges after they change (default 2). A level that changes only one cycle before a pulse is not seen by that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_en | input | 1 | Soft-start has reached the point where the window loop may act |
| cmp_low | input | 1 | Asynchronous: output more than 3% below reference |
| cmp_high | input | 1 | Asynchronous: output more than 3% above reference |
| ref_cross | input | 1 | Asynchronous: output has passed through its regulation point |
| on_set | input | 1 | Single-cycle pulse at the start of a main-loop on-time (current valley) |
| on_reset | input | 1 | Single-cycle pulse at the end of a main-loop on-time (current peak) |
| ovr_valid | output | 1 | Override is active; the downstream mux takes `ovr_pwm` |
| ovr_pwm | output | 1 | Override PWM value: 1 forces the switch on, 0 forces it off |

## Verification
The hardest case to reach is an output near a threshold whose ripple straddles it. A correct design must accept the comparator only at one edge of the on-time and ignore it at the other. The bench models the converter output as a millivolt value and drives the comparators from thresholds at 1213 mV and 1287 mV. It places the valley level before each start pulse and the peak level before each end pulse. This shows that a ripple just inside either window never latches, while a step beyond it latches on the correct edge. Random centres, ripple amplitudes, crossings and enable drops then mix latch, hold and release in sequences that no directed test lists.

// File: rtl/rwo_pkg.sv
package rwo_pkg;
  typedef enum logic [1:0] {
    OVR_IDLE      = 2'd0,
    OVR_FORCE_ON  = 2'd1,
    OVR_FORCE_OFF = 2'd2
  } ovr_state_t;

  localparam int unsigned LVL_W = 3;
  localparam int unsigned LVL_LOW   = 2;
  localparam int unsigned LVL_HIGH  = 1;
  localparam int unsigned LVL_CROSS = 0;
endpackage

// File: rtl/rwo_sync.sv
module rwo_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_out = d_in;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d_in;
          end
        end else begin : g_next
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
          end
        end
      end
      assign q_out = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rwo_sampler.sv
module rwo_sampler (
  input  logic low_s,
  input  logic high_s,
  input  logic cross_s,
  input  logic on_set,
  input  logic on_reset,
  output logic req_on,
  output logic req_off
);
  logic conflict;
  logic blocked;

  always_comb begin
    conflict = low_s & high_s;
    blocked  = conflict | cross_s;
    req_on   = on_reset & low_s  & ~blocked;
    req_off  = on_set   & high_s & ~blocked;
  end
endmodule

// File: rtl/rwo_state.sv
module rwo_state
  import rwo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic win_en,
  input  logic cross_s,
  input  logic req_on,
  input  logic req_off,
  output logic ovr_valid,
  output logic ovr_pwm
);
  ovr_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!win_en) begin
      state_d = OVR_IDLE;
    end else if (state_q != OVR_IDLE) begin
      if (cross_s) state_d = OVR_IDLE;
    end else if (req_on) begin
      state_d = OVR_FORCE_ON;
    end else if (req_off) begin
      state_d = OVR_FORCE_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= OVR_IDLE;
    else        state_q <= state_d;
  end

  assign ovr_valid = (state_q != OVR_IDLE);
  assign ovr_pwm   = (state_q == OVR_FORCE_ON);
endmodule

// File: rtl/ripple_window_override.sv
module ripple_window_override
  import rwo_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_en,
  input  logic cmp_low,
  input  logic cmp_high,
  input  logic ref_cross,
  input  logic on_set,
  input  logic on_reset,
  output logic ovr_valid,
  output logic ovr_pwm
);
  logic [LVL_W-1:0] lvl_raw, lvl_s;
  logic low_s, high_s, cross_s;
  logic req_on, req_off;

  always_comb begin
    lvl_raw            = '0;
    lvl_raw[LVL_LOW]   = cmp_low;
    lvl_raw[LVL_HIGH]  = cmp_high;
    lvl_raw[LVL_CROSS] = ref_cross;
  end

  rwo_sync #(.WIDTH(LVL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (lvl_raw),
    .q_out (lvl_s)
  );

  assign low_s   = lvl_s[LVL_LOW];
  assign high_s  = lvl_s[LVL_HIGH];
  assign cross_s = lvl_s[LVL_CROSS];

  rwo_sampler u_sampler (
    .low_s    (low_s),
    .high_s   (high_s),
    .cross_s  (cross_s),
    .on_set   (on_set),
    .on_reset (on_reset),
    .req_on   (req_on),
    .req_off  (req_off)
  );

  rwo_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_en    (win_en),
    .cross_s   (cross_s),
    .req_on    (req_on),
    .req_off   (req_off),
    .ovr_valid (ovr_valid),
    .ovr_pwm   (ovr_pwm)
  );
endmodule

// File: rtl/rwo_checker.sv
module rwo_checker (
  input logic clk,
  input logic rst_n,
  input logic win_en,
  input logic on_set,
  input logic on_reset,
  input logic cross_s,
  input logic ovr_valid,
  input logic ovr_pwm
);
  // R1: force value only exists while an override is active
  p_pwm_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_pwm |-> ovr_valid);

  // R2: a force-on starts only after an end-of-on-time pulse
  p_on_from_peak_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovr_valid) && ovr_pwm) |-> $past(on_reset));

  // R3: a force-off starts only after a start-of-on-time pulse
  p_off_from_valley_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovr_valid) && !ovr_pwm) |-> $past(on_set));

  // R5: an active override holds its value until a crossing or disable
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid && win_en && !cross_s) |=> (ovr_valid && $stable(ovr_pwm)));

  // R5: a crossing releases the override
  p_cross_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid && cross_s) |=> !ovr_valid);

  // R6: disabled means no override next cycle
  p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |=> !ovr_valid);
endmodule

bind ripple_window_override rwo_checker u_rwo_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .win_en    (win_en),
  .on_set    (on_set),
  .on_reset  (on_reset),
  .cross_s   (cross_s),
  .ovr_valid (ovr_valid),
  .ovr_pwm   (ovr_pwm)
);

// File: tb/ripple_window_override_tb_top.sv
module ripple_window_override_tb_top;
  localparam int LOW_MV  = 1213;
  localparam int HIGH_MV = 1287;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_en = 1'b0;
  logic cmp_low = 1'b0, cmp_high = 1'b0, ref_cross = 1'b0;
  logic on_set = 1'b0, on_reset = 1'b0;
  logic ovr_valid, ovr_pwm;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  // expected state: 0 idle, 1 force on, 2 force off
  int exp_st = 0;

  always #4 clk = ~clk;

  ripple_window_override #(.SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .win_en(win_en),
    .cmp_low(cmp_low), .cmp_high(cmp_high), .ref_cross(ref_cross),
    .on_set(on_set), .on_reset(on_reset),
    .ovr_valid(ovr_valid), .ovr_pwm(ovr_pwm)
  );

  function automatic bit is_low(int mv);  return mv < LOW_MV;  endfunction
  function automatic bit is_high(int mv); return mv > HIGH_MV; endfunction

  // expected next state after a pulse, from the requirements
  function automatic int after_pulse(int st, bit at_peak, bit lo, bit hi,
                                     bit cr, bit en);
    if (!en) return 0;
    if (st != 0) return cr ? 0 : st;
    if (cr || (lo && hi)) return 0;
    if (at_peak && lo) return 1;
    if (!at_peak && hi) return 2;
    return 0;
  endfunction

  task automatic check(string req);
    logic [1:0] e;
    e = (exp_st == 1) ? 2'b11 : (exp_st == 2) ? 2'b10 : 2'b00;
    tests++;
    if ({ovr_valid, ovr_pwm} !== e) begin
      fails++;
      $display("[TB] FAIL %s: valid/pwm=%b expected %b", req,
               {ovr_valid, ovr_pwm}, e);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic drive_mv(int mv);
    cmp_low  = is_low(mv);
    cmp_high = is_high(mv);
  endtask

  task automatic pulse(bit at_peak);
    if (at_peak) on_reset = 1'b1; else on_set = 1'b1;
    @(negedge clk);
    on_reset = 1'b0;
    on_set   = 1'b0;
    exp_st = after_pulse(exp_st, at_peak, cmp_low, cmp_high, ref_cross, win_en);
  endtask

  task automatic ripple(int centre, int amp, string req);
    drive_mv(centre - amp); settle(); pulse(1'b0); check(req);
    drive_mv(centre + amp); settle(); pulse(1'b1); check(req);
  endtask

  task automatic crossing(string req);
    ref_cross = 1'b1; settle();
    exp_st = 0; check(req);
    ref_cross = 1'b0; drive_mv(1250); settle();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    win_en = 1'b1;
    drive_mv(1250); settle();

    // just inside the low window: valley low at set, peak inside at reset
    ripple(1215, 10, "R4");
    // step well below: latches at peak
    ripple(1180, 10, "R2");
    // more pulses while latched, including a high level at valley
    ripple(1180, 10, "R5");
    drive_mv(1300); settle(); pulse(1'b0); check("R5");
    crossing("R5");
    // above the window: latches at valley
    ripple(1300, 8, "R3");
    ripple(1300, 8, "R5");
    crossing("R5");
    // just inside the high window: peak high only at reset
    ripple(1285, 8, "R4");

    // both comparators at once
    cmp_low = 1'b1; cmp_high = 1'b1; settle();
    pulse(1'b1); check("R7");
    pulse(1'b0); check("R7");
    drive_mv(1250); settle();

    // crossing present while a valid low is sampled
    ref_cross = 1'b1; drive_mv(1180); settle();
    pulse(1'b1); check("R8");
    ref_cross = 1'b0; drive_mv(1250); settle();

    // disabled
    win_en = 1'b0; drive_mv(1180); settle();
    pulse(1'b1); check("R6");
    win_en = 1'b1; settle(); pulse(1'b1); check("R2");
    win_en = 1'b0; @(negedge clk); exp_st = 0; check("R6");
    win_en = 1'b1; drive_mv(1250); settle();

    // level changes one cycle before the pulse: not yet visible
    drive_mv(1180);
    @(negedge clk);
    on_reset = 1'b1; @(negedge clk); on_reset = 1'b0;
    check("R9");
    drive_mv(1250); settle();

    // random mix
    for (int i = 0; i < 300; i++) begin
      int centre, amp;
      centre = 1150 + int'($urandom_range(0, 200));
      amp = int'($urandom_range(0, 30));
      if ($urandom_range(0, 15) == 0) begin
        win_en = 1'b0; settle(); exp_st = 0; check("R6");
        win_en = 1'b1;
      end
      ripple(centre, amp, "R5");
      if ($urandom_range(0, 3) == 0) crossing("R5");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("[TB] FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule